// File: doc/BRIEF.md
# Byte/Word Data Access Aligner

This block sits between a load/store unit and a data memory that is 16 bits wide and byte addressable. Each request carries a byte effective address, a size flag (byte or word), a direction flag, write data and a pointer operation. In the same cycle, the block turns the request into a word address, a pair of byte-lane enables, steered write data and read/write strobes for the memory. It also computes the modified value of the pointer register that produced the address.

Read data comes back from the memory one cycle after the strobe. The block then picks the requested byte or passes the whole word, and widens a byte to 16 bits by zero or sign extension.

A word access at an odd byte address is not performed. Instead, the block raises an address-fault trap in the request cycle. It also blocks every strobe and the pointer write, so the machine state stays as it was and software can inspect it.

Top module: `data_access_aligner`

## Requirements
- R1: For a valid access that does not fault, `mem_addr` equals `req_ea` shifted right by one. A read asserts `mem_re` in the request cycle, and `rd_valid` goes high exactly one cycle later.
- R2: A byte read with `req_sext`=0 returns the byte selected by address bit 0 (0 selects bits 7:0, 1 selects bits 15:8) in `rd_data[7:0]`, with `rd_data[15:8]`=0.
- R3: A byte read with `req_sext`=1 fills `rd_data[15:8]` with bit 7 of the selected byte.
- R4: A word read at an even address returns the whole stored word unchanged.
- R5: A byte write places the write byte `req_wdata[7:0]` on both halves of `mem_wdata`. It sets `mem_be`=2'b01 when address bit 0 is 0 and 2'b10 when it is 1. Only that byte of the memory word changes.
- R6: A word write at an even address sets `mem_be`=2'b11, passes `req_wdata` unchanged and asserts `mem_we`.
- R7: A word read or write at an odd address raises `trap` in the same cycle, with `mem_we`=0, `mem_re`=0 and `mem_be`=2'b00. Memory contents are not altered.
- R8: In a trap cycle, `ptr_we`=0 and `ptr_out` equals `ptr_in`. No `rd_valid` follows in the next cycle.
- R9: `ptr_mode`=2'b01 (post-increment) on a valid access without a fault gives `ptr_we`=1, and `ptr_out` = `ptr_in`+1 for a byte access or +2 for a word access.
- R10: `ptr_mode`=2'b10 (post-decrement) gives `ptr_we`=1, and `ptr_out` = `ptr_in`-1 for a byte access or -2 for a word access.
- R11: Pointer arithmetic wraps modulo 2^16, so 0xFFFE+2=0x0000 and 0x0000-1=0xFFFF.
- R12: `ptr_mode` 2'b00 or 2'b11 leaves `ptr_we`=0. With `req_valid`=0 no strobe, lane enable or pointer write is asserted.
- R13: While `rst_n` is low, and in the first cycle after it is released, `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_sext | input | 1 | Sign-extend a byte read |
| req_ea | input | 16 | Byte effective address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| ptr_mode | input | 2 | 00/11 hold, 01 post-increment, 10 post-decrement |
| ptr_in | input | 16 | Current pointer value |
| mem_addr | output | 15 | Word address to memory |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_be | output | 2 | Byte-lane enables (bit 0 = bits 7:0) |
| mem_wdata | output | 16 | Steered write data |
| mem_rdata | input | 16 | Word read data, one cycle after `mem_re` |
| rd_valid | output | 1 | Formatted read data valid |
| rd_data | output | 16 | Aligned, extended read data |
| trap | output | 1 | Address-fault trap for an odd word access |
| ptr_out | output | 16 | Updated pointer value |
| ptr_we | output | 1 | Pointer write-back enable |

## Verification
The hardest situation to show from the ports is that a faulting odd word write really leaves memory untouched. The trap flag alone proves nothing about storage, because the blocked strobe has no visible effect of its own. The stimulus therefore attempts an odd word write into a word that has never been written. Later it reads that word back at its even address and expects the reset contents, and it also expects no read-valid in the cycle after a faulting read. Pointer wrap is reached by placing the pointer at 0xFFFE, 0xFFFF and 0x0000 while the access itself is legal.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

   localparam int unsigned DATA_W  = 16;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned LANES   = DATA_W / BYTE_W;

   typedef enum logic [1:0] {
      PTR_KEEP     = 2'b00,
      PTR_POST_INC = 2'b01,
      PTR_POST_DEC = 2'b10,
      PTR_KEEP_ALT = 2'b11
   } ptr_op_e;

   typedef struct packed {
      logic hi_lane;
      logic is_byte;
      logic sext;
   } rd_fmt_t;

   function automatic logic [BYTE_W-1:0] pick_lane(input logic [DATA_W-1:0] word,
                                                   input logic hi);
      return hi ? word[DATA_W-1:BYTE_W] : word[BYTE_W-1:0];
   endfunction

endpackage

// File: rtl/ea_decode.sv
module ea_decode
   import aligner_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
)(
   input  logic              valid,
   input  logic              is_byte,
   input  logic [ADDR_W-1:0] ea,
   output logic              fault,
   output logic              go,
   output logic [LANES-1:0]  lanes,
   output logic [ADDR_W-2:0] word_addr
);

   logic odd;

   always_comb begin
      odd       = ea[0];
      fault     = valid & ~is_byte & odd;
      go        = valid & ~fault;
      word_addr = ea[ADDR_W-1:1];
      lanes     = '0;
      if (go) begin
         if (is_byte) begin
            lanes[odd] = 1'b1;
         end else begin
            lanes = '1;
         end
      end
   end

endmodule

// File: rtl/write_steer.sv
module write_steer
   import aligner_pkg::*;
(
   input  logic              is_byte,
   input  logic [DATA_W-1:0] wdata_in,
   output logic [DATA_W-1:0] wdata_out
);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign wdata_out[g*BYTE_W +: BYTE_W] =
            is_byte ? wdata_in[BYTE_W-1:0] : wdata_in[g*BYTE_W +: BYTE_W];
      end
   endgenerate

endmodule

// File: rtl/ptr_update.sv
module ptr_update
   import aligner_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
)(
   input  logic              allow,
   input  logic              is_byte,
   input  ptr_op_e           op,
   input  logic [ADDR_W-1:0] ptr_in,
   output logic [ADDR_W-1:0] ptr_out,
   output logic              ptr_we
);

   localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(LANES);

   logic [ADDR_W-1:0] step;

   always_comb begin
      step    = is_byte ? STEP_BYTE : STEP_WORD;
      ptr_out = ptr_in;
      ptr_we  = 1'b0;
      if (allow) begin
         unique case (op)
            PTR_POST_INC: begin
               ptr_out = ptr_in + step;
               ptr_we  = 1'b1;
            end
            PTR_POST_DEC: begin
               ptr_out = ptr_in - step;
               ptr_we  = 1'b1;
            end
            default: begin
               ptr_out = ptr_in;
               ptr_we  = 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/read_format.sv
module read_format
   import aligner_pkg::*;
#(
   parameter bit SEXT_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  rd_fmt_t           fmt_in,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   rd_fmt_t           fmt_q;
   logic [BYTE_W-1:0] sel;
   logic              fill;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         fmt_q    <= '0;
      end else begin
         rd_valid <= capture;
         if (capture) begin
            fmt_q <= fmt_in;
         end
      end
   end

   assign sel = pick_lane(mem_rdata, fmt_q.hi_lane);

   generate
      if (SEXT_EN) begin : g_sext
         assign fill = fmt_q.sext & sel[BYTE_W-1];
      end else begin : g_zext
         assign fill = 1'b0;
      end
   endgenerate

   assign rd_data = fmt_q.is_byte ? {{(DATA_W-BYTE_W){fill}}, sel} : mem_rdata;

endmodule

// File: rtl/data_access_aligner.sv
module data_access_aligner
   import aligner_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter bit          SEXT_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_byte,
   input  logic              req_sext,
   input  logic [ADDR_W-1:0] req_ea,
   input  logic [15:0]       req_wdata,
   input  logic [1:0]        ptr_mode,
   input  logic [ADDR_W-1:0] ptr_in,
   output logic [ADDR_W-2:0] mem_addr,
   output logic              mem_we,
   output logic              mem_re,
   output logic [1:0]        mem_be,
   output logic [15:0]       mem_wdata,
   input  logic [15:0]       mem_rdata,
   output logic              rd_valid,
   output logic [15:0]       rd_data,
   output logic              trap,
   output logic [ADDR_W-1:0] ptr_out,
   output logic              ptr_we
);

   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr_w
         $error("data_access_aligner: ADDR_W must lie in 2..32");
      end
      if (DATA_W != 16 || LANES != 2) begin : g_bad_data_w
         $error("data_access_aligner: data path must be two byte lanes");
      end
   endgenerate

   logic    fault;
   logic    go;
   rd_fmt_t fmt;

   ea_decode #(.ADDR_W(ADDR_W)) i_decode (
      .valid     (req_valid),
      .is_byte   (req_byte),
      .ea        (req_ea),
      .fault     (fault),
      .go        (go),
      .lanes     (mem_be),
      .word_addr (mem_addr)
   );

   write_steer i_steer (
      .is_byte   (req_byte),
      .wdata_in  (req_wdata),
      .wdata_out (mem_wdata)
   );

   ptr_update #(.ADDR_W(ADDR_W)) i_ptr (
      .allow   (go),
      .is_byte (req_byte),
      .op      (ptr_op_e'(ptr_mode)),
      .ptr_in  (ptr_in),
      .ptr_out (ptr_out),
      .ptr_we  (ptr_we)
   );

   assign fmt.hi_lane = req_ea[0];
   assign fmt.is_byte = req_byte;
   assign fmt.sext    = req_sext;

   read_format #(.SEXT_EN(SEXT_EN)) i_fmt (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (mem_re),
      .fmt_in    (fmt),
      .mem_rdata (mem_rdata),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

   assign mem_we = go &  req_write;
   assign mem_re = go & ~req_write;
   assign trap   = fault;

endmodule

// File: rtl/aligner_checker.sv
module aligner_checker #(
   parameter int unsigned ADDR_W = 16
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_byte,
   input logic [ADDR_W-1:0] req_ea,
   input logic [1:0]        ptr_mode,
   input logic [ADDR_W-1:0] ptr_in,
   input logic [ADDR_W-2:0] mem_addr,
   input logic              mem_we,
   input logic              mem_re,
   input logic [1:0]        mem_be,
   input logic              rd_valid,
   input logic              trap,
   input logic [ADDR_W-1:0] ptr_out,
   input logic              ptr_we
);

   AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_re || mem_we) |-> mem_addr == req_ea[ADDR_W-1:1]); // R1
   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> rd_valid); // R1
   AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && req_byte) |-> $countones(mem_be) == 1); // R5
   AST_TRAP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> (!mem_we && !mem_re && mem_be == 2'b00)); // R7
   AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> (req_valid && !req_byte && req_ea[0])); // R7
   AST_TRAP_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> (!ptr_we && ptr_out == ptr_in)); // R8
   AST_NO_DATA_AFTER_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      trap |=> !rd_valid); // R8
   AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_we && ptr_mode == 2'b01) |-> ADDR_W'(ptr_out - ptr_in) == (req_byte ? ADDR_W'(1) : ADDR_W'(2))); // R9
   AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_we && ptr_mode == 2'b10) |-> ADDR_W'(ptr_in - ptr_out) == (req_byte ? ADDR_W'(1) : ADDR_W'(2))); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!mem_we && !mem_re && !ptr_we && mem_be == 2'b00)); // R12

endmodule

bind data_access_aligner aligner_checker #(.ADDR_W(ADDR_W)) i_aligner_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_byte  (req_byte),
   .req_ea    (req_ea),
   .ptr_mode  (ptr_mode),
   .ptr_in    (ptr_in),
   .mem_addr  (mem_addr),
   .mem_we    (mem_we),
   .mem_re    (mem_re),
   .mem_be    (mem_be),
   .rd_valid  (rd_valid),
   .trap      (trap),
   .ptr_out   (ptr_out),
   .ptr_we    (ptr_we)
);

// File: tb/test_data_access_aligner.sv
`timescale 1ns/1ps
module test_data_access_aligner;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0, req_sext = 1'b0;
   logic [15:0] req_ea = '0, req_wdata = '0, ptr_in = '0;
   logic [1:0]  ptr_mode = 2'b00;
   logic [14:0] mem_addr;
   logic        mem_we, mem_re, rd_valid, trap, ptr_we;
   logic [1:0]  mem_be;
   logic [15:0] mem_wdata, rd_data, ptr_out;
   logic [15:0] mem_rdata = '0;
   logic [15:0] mem [16];

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   data_access_aligner i_data_access_aligner (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_byte(req_byte), .req_sext(req_sext), .req_ea(req_ea), .req_wdata(req_wdata),
      .ptr_mode(ptr_mode), .ptr_in(ptr_in), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_re(mem_re), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .trap(trap), .ptr_out(ptr_out), .ptr_we(ptr_we)
   );

   // memory model: synchronous read, byte-enabled write
   initial for (int k = 0; k < 16; k++) mem[k] = '0;
   always @(posedge clk) begin
      if (mem_we) begin
         if (mem_be[0]) mem[mem_addr[3:0]][7:0]  <= mem_wdata[7:0];
         if (mem_be[1]) mem[mem_addr[3:0]][15:8] <= mem_wdata[15:8];
      end
      if (mem_re) mem_rdata <= mem[mem_addr[3:0]];
   end

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   typedef struct packed {
      logic        wr, byt, sx;
      logic [15:0] ea, wd;
      logic [1:0]  mode;
      logic [15:0] pin;
      logic        x_trap;
      logic [1:0]  x_be;
      logic [15:0] x_wd, x_ptr;
      logic        x_pwe;
      logic [15:0] x_rd;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b0,1'b0,16'h0010,16'h1234,2'b01,16'h0010,1'b0,2'b11,16'h1234,16'h0012,1'b1,16'h0000},
      '{1'b1,1'b1,1'b0,16'h0013,16'h00C7,2'b10,16'h0013,1'b0,2'b10,16'hC7C7,16'h0012,1'b1,16'h0000},
      '{1'b1,1'b1,1'b0,16'h0012,16'hFF5A,2'b00,16'h0100,1'b0,2'b01,16'h5A5A,16'h0100,1'b0,16'h0000},
      '{1'b1,1'b0,1'b0,16'h0015,16'hDEAD,2'b01,16'h0015,1'b1,2'b00,16'h0000,16'h0015,1'b0,16'h0000},
      '{1'b0,1'b0,1'b0,16'h0010,16'h0000,2'b01,16'hFFFE,1'b0,2'b11,16'h0000,16'h0000,1'b1,16'h1234},
      '{1'b0,1'b1,1'b0,16'h0013,16'h0000,2'b10,16'h0000,1'b0,2'b10,16'h0000,16'hFFFF,1'b1,16'h00C7},
      '{1'b0,1'b1,1'b1,16'h0013,16'h0000,2'b01,16'hFFFF,1'b0,2'b10,16'h0000,16'h0000,1'b1,16'hFFC7},
      '{1'b0,1'b1,1'b1,16'h0012,16'h0000,2'b10,16'h0001,1'b0,2'b01,16'h0000,16'h0000,1'b1,16'h005A},
      '{1'b0,1'b1,1'b0,16'h0012,16'h0000,2'b11,16'h4444,1'b0,2'b01,16'h0000,16'h4444,1'b0,16'h005A},
      '{1'b0,1'b0,1'b0,16'h0011,16'h0000,2'b01,16'h0011,1'b1,2'b00,16'h0000,16'h0011,1'b0,16'h0000},
      '{1'b0,1'b0,1'b0,16'h0014,16'h0000,2'b10,16'h0000,1'b0,2'b11,16'h0000,16'hFFFE,1'b1,16'h0000},
      '{1'b0,1'b0,1'b0,16'h0012,16'h0000,2'b00,16'h0000,1'b0,2'b11,16'h0000,16'h0000,1'b0,16'hC75A},
      '{1'b1,1'b0,1'b0,16'h001E,16'h8001,2'b10,16'h0000,1'b0,2'b11,16'h8001,16'hFFFE,1'b1,16'h0000},
      '{1'b0,1'b1,1'b1,16'h001F,16'h0000,2'b00,16'h0000,1'b0,2'b10,16'h0000,16'h0000,1'b0,16'hFF80},
      '{1'b0,1'b1,1'b1,16'h001E,16'h0000,2'b00,16'h0000,1'b0,2'b01,16'h0000,16'h0000,1'b0,16'h0001}
   };

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : main
      string tb, tp, tr;
      // R13: reset state
      repeat (3) @(negedge clk);
      check("R13 rd_valid in reset", {15'b0, rd_valid}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R13 rd_valid after reset", {15'b0, rd_valid}, 16'h0000);

      // R12: idle request with write and increment must be quiet
      req_valid = 1'b0; req_write = 1'b1; ptr_mode = 2'b01; req_ea = 16'h0002;
      #1;
      check("R12 idle strobes", {12'b0, mem_we, mem_re, mem_be}, 16'h0000);
      check("R12 idle ptr_we", {15'b0, ptr_we}, 16'h0000);
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         req_valid = 1'b1;
         req_write = VECS[i].wr;  req_byte = VECS[i].byt; req_sext = VECS[i].sx;
         req_ea    = VECS[i].ea;  req_wdata = VECS[i].wd; ptr_mode = VECS[i].mode;
         ptr_in    = VECS[i].pin;
         #1;
         tb = VECS[i].wr ? (VECS[i].byt ? "R5 lanes" : "R6 lanes") : "R1 lanes";
         if (VECS[i].x_trap) tb = "R7 lanes";
         tp = (VECS[i].mode == 2'b01) ? "R9 ptr" : (VECS[i].mode == 2'b10) ? "R10 ptr" : "R12 ptr";
         if (VECS[i].x_trap) tp = "R8 ptr";
         check("R7 trap", {15'b0, trap}, {15'b0, VECS[i].x_trap});
         check(tb, {14'b0, mem_be}, {14'b0, VECS[i].x_be});
         check("R7 mem_we", {15'b0, mem_we}, {15'b0, VECS[i].wr & ~VECS[i].x_trap});
         check("R7 mem_re", {15'b0, mem_re}, {15'b0, ~VECS[i].wr & ~VECS[i].x_trap});
         check(tp, ptr_out, VECS[i].x_ptr);
         check(tp, {15'b0, ptr_we}, {15'b0, VECS[i].x_pwe});
         if (VECS[i].wr && !VECS[i].x_trap)
            check(VECS[i].byt ? "R5 wdata" : "R6 wdata", mem_wdata, VECS[i].x_wd);
         if (!VECS[i].x_trap)
            check("R1 mem_addr", {1'b0, mem_addr}, {1'b0, VECS[i].ea[15:1]});
         @(negedge clk);
         tr = VECS[i].x_trap ? "R8 rd_valid" : "R1 rd_valid";
         check(tr, {15'b0, rd_valid}, {15'b0, ~VECS[i].wr & ~VECS[i].x_trap});
         if (!VECS[i].wr && !VECS[i].x_trap) begin
            tr = VECS[i].byt ? (VECS[i].sx ? "R3 rd_data" : "R2 rd_data") : "R4 rd_data";
            check(tr, rd_data, VECS[i].x_rd);
         end
      end

      // R11: wrap corners, pointer only
      req_write = 1'b0; req_byte = 1'b0; req_ea = 16'h0000;
      ptr_mode = 2'b01; ptr_in = 16'hFFFE; #1;
      check("R11 inc wrap", ptr_out, 16'h0000);
      req_byte = 1'b1; ptr_mode = 2'b10; ptr_in = 16'h0000; #1;
      check("R11 dec wrap", ptr_out, 16'hFFFF);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      // R7: memory word behind the faulting write still at reset contents
      check("R7 memory untouched", mem[10], 16'h0000);
      finish_run();
   end

endmodule